// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

A single-clock static memory with registered inputs. Reads, writes and deselects may follow one another in any order on consecutive clock edges, with no idle cycle when the bus turns from reading to writing or back. All address, control and byte-enable inputs are captured on the rising edge. The write data for a write cycle arrives one enabled clock after its address. The address and lane enables of that write wait in a pending-write register, and the pending write is committed to the array on the next enabled edge. A read that targets the pending address receives the byte-merged new word. The read does not receive the stale array contents.

An active-low clock enable freezes the whole block. A load/advance control either starts a new cycle from the external address or continues the current operation through a four-beat burst. The burst order is either linear or interleaved, chosen by a strap input. Three chip selects gate new cycles. Read data comes out of a register, and an output enable masks it. The depth and the lane geometry are parameters.

Top module: `zt_sram`

## Requirements
- R1: Every read returns the word last written to its address, for any interleaving of reads, writes and deselects on consecutive enabled edges.
- R2: A read whose address is registered on enabled edge k drives `rd_vld` high and `rd_data` with the word on enabled edge k+1. On edges that do not follow a read, `rd_vld` is low.
- R3: While `cke_n` is high, every input is ignored and all state, including `rd_data` and `rd_vld`, holds its value.
- R4: The write data is sampled from `din` on the first enabled edge after the write address. The value of `din` on the address edge, or during stalled cycles, has no effect.
- R5: `bw_n[i]` low on the address edge enables byte lane i, which is bits `[8*i+7:8*i]` by default. Lanes whose bit is high keep their old contents.
- R6: A new cycle is selected only when `cs_a_n` is 0, `cs_b` is 1 and `cs_c_n` is 0. Otherwise it is a deselect: nothing is written and no read result appears.
- R7: A read issued on the edge that supplies a pending write's data, to the same address, returns the merged new word.
- R8: With `load_n` high, the previous operation continues. Chip selects and `we_n` are ignored. The beat counter increments modulo 4. When `ilv`=0, the two low address bits are base+count mod 4.
- R9: When `ilv`=1, the two low address bits are base XOR count.
- R10: `oe_n` high forces `rd_vld` to 0 and `rd_data` to zero at once, without disturbing the held result.
- R11: After reset, `rd_vld` is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high stalls the block |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low: new cycle at `addr`; high: burst advance |
| we_n | input | 1 | Low: write, high: read (on a load) |
| ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| bw_n | input | LANES | Active-low byte-lane write enables |
| din | input | LANES*LANE_W | Write data, one enabled clock after its address |
| oe_n | input | 1 | Active-low output enable |
| rd_data | output | LANES*LANE_W | Read data |
| rd_vld | output | 1 | Read data valid |

## Verification
Read results are due exactly one enabled edge after the read's address edge. Write data is taken one enabled edge after the address. The bench counts enabled edges itself, and each expected word is stamped with the enabled-edge number at which it must appear. The monitor samples 2 ns after every enabled edge and compares only the entry whose stamp matches. On every other enabled edge it demands that `rd_vld` be low. Stalled edges advance no count, so results delayed by `cke_n` are checked after the stall, against the same values.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke_n,
  input  logic                     cs_a_n,
  input  logic                     cs_b,
  input  logic                     cs_c_n,
  input  logic                     load_n,
  input  logic                     we_n,
  input  logic                     ilv,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES-1:0]         bw_n,
  input  logic [LANES*LANE_W-1:0]  din,
  input  logic                     oe_n,
  output logic [LANES*LANE_W-1:0]  rd_data,
  output logic                     rd_vld
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_t;

  op_t               op_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [LANES-1:0]  be_q;
  logic              pv_q;
  logic [ADDR_W-1:0] pa_q;
  logic [LANES-1:0]  pbe_q;
  logic [DATA_W-1:0] pd_q;
  logic [DATA_W-1:0] dout_q;
  logic              vld_q;

  logic              sel;
  logic [1:0]        lo;
  logic [ADDR_W-1:0] eff;
  logic              hit;
  logic [DATA_W-1:0] merged;

  assign sel = !cs_a_n && cs_b && !cs_c_n;
  assign lo  = ilv ? (base_q[1:0] ^ cnt_q) : (base_q[1:0] + cnt_q);
  assign eff = {base_q[ADDR_W-1:2], lo};
  assign hit = pv_q && (pa_q == eff);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk)
      if (!cke_n && pv_q && pbe_q[i])
        cells[pa_q] <= pd_q[i*LANE_W +: LANE_W];
    assign merged[i*LANE_W +: LANE_W] =
      (hit && pbe_q[i]) ? pd_q[i*LANE_W +: LANE_W] : cells[eff];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      be_q   <= '0;
      pv_q   <= 1'b0;
      pa_q   <= '0;
      pbe_q  <= '0;
      pd_q   <= '0;
      dout_q <= '0;
      vld_q  <= 1'b0;
    end else if (!cke_n) begin
      if (!load_n) begin
        op_q   <= sel ? (we_n ? OP_RD : OP_WR) : OP_IDLE;
        base_q <= addr;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 2'd1;
      end
      be_q  <= ~bw_n;
      pv_q  <= (op_q == OP_WR);
      pa_q  <= eff;
      pbe_q <= be_q;
      pd_q  <= din;
      vld_q <= (op_q == OP_RD);
      if (op_q == OP_RD) dout_q <= merged;
    end
  end

  assign rd_data = oe_n ? '0 : dout_q;
  assign rd_vld  = vld_q && !oe_n;

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(dout_q) && $stable(vld_q) && $stable(op_q) && $stable(pv_q) && $stable(cnt_q)); // R3
  AST_LATE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && op_q == OP_WR) |=> pv_q); // R4
  AST_NO_STRAY_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && op_q != OP_WR) |=> !pv_q); // R4
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && op_q == OP_RD) |=> vld_q); // R2
  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !load_n && !sel) |=> op_q == OP_IDLE); // R6
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && load_n) |=> (cnt_q == $past(cnt_q) + 2'd1) && $stable(op_q)); // R8
endmodule

// File: tb/tb_zt_sram.sv
`timescale 1ns/1ps
module tb_zt_sram;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke_n = 1'b0, cs_a_n = 1'b1, cs_b = 1'b0, cs_c_n = 1'b1;
  logic load_n = 1'b0, we_n = 1'b1, ilv = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] bw_n = 4'hF;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] rd_data;
  logic rd_vld;

  zt_sram dut (.clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .cs_c_n(cs_c_n), .load_n(load_n), .we_n(we_n), .ilv(ilv), .addr(addr), .bw_n(bw_n),
    .din(din), .oe_n(oe_n), .rd_data(rd_data), .rd_vld(rd_vld));

  always #4 clk = ~clk;

  typedef struct { int due; logic [DW-1:0] data; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0, en_cnt = 0, brk_rr = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [64];
  int m_op = 0, m_cnt = 0;
  logic [AW-1:0] m_base = '0, m_pa = '0;
  logic [3:0] m_pbw = '0;
  logic [DW-1:0] m_pd = '0;
  bit m_pv = 0;

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic drive(bit stall, bit ld, bit wr, bit selok, logic [AW-1:0] a,
                       logic [3:0] bw, logic [DW-1:0] wd, bit oe, string tag);
    logic [1:0] lo;
    logic [AW-1:0] eff;
    int brk;
    @(negedge clk);
    cke_n = stall; load_n = !ld; we_n = !wr; oe_n = !oe; addr = a; bw_n = bw;
    if (selok) begin cs_a_n = 0; cs_b = 1; cs_c_n = 0; end
    else begin
      brk = brk_rr; brk_rr = (brk_rr + 1) % 3;
      cs_a_n = (brk == 0); cs_b = (brk != 1); cs_c_n = (brk == 2);
    end
    din = (!stall && m_pv) ? m_pd : DW'($urandom);
    if (!stall) begin
      if (m_pv) begin
        for (int i = 0; i < 4; i++)
          if (!m_pbw[i]) ref_mem[m_pa][i*8 +: 8] = m_pd[i*8 +: 8];
        m_pv = 0;
      end
      if (ld) begin m_op = selok ? (wr ? 2 : 1) : 0; m_base = a; m_cnt = 0; end
      else m_cnt = (m_cnt + 1) % 4;
      lo = ilv ? (m_base[1:0] ^ 2'(m_cnt)) : (m_base[1:0] + 2'(m_cnt));
      eff = {m_base[AW-1:2], lo};
      if (m_op == 1) q.push_back('{due: en_cnt + 2, data: ref_mem[eff], tag: tag});
      if (m_op == 2) begin m_pv = 1; m_pa = eff; m_pbw = bw; m_pd = wd; end
    end
  endtask

  task automatic wr1(logic [AW-1:0] a, logic [DW-1:0] d);
    drive(0, 1, 1, 1, a, 4'h0, d, 1, "R1");
  endtask
  task automatic rd1(logic [AW-1:0] a, string tag);
    drive(0, 1, 0, 1, a, 4'h0, '0, 1, tag);
  endtask
  task automatic nop();
    drive(0, 1, 0, 0, '0, 4'hF, '0, 1, "R6");
  endtask
  task automatic adv(bit wr, logic [DW-1:0] d, string tag);
    drive(0, 0, !wr, 0, 6'h3F, 4'h0, d, 1, tag);
  endtask

  always @(posedge clk) begin
    if (rst_n && !cke_n) begin
      item_t it;
      bit exp_v;
      en_cnt++;
      #2;
      exp_v = (q.size() > 0) && (q[0].due == en_cnt);
      if (exp_v) begin
        it = q.pop_front();
        if (oe_n) chk(!rd_vld && rd_data == '0, "R10", rd_data, '0);
        else begin
          chk(rd_vld === 1'b1, "R2", DW'(rd_vld), 1);
          chk(rd_data === it.data, it.tag, rd_data, it.data);
        end
      end else begin
        chk(rd_vld === 1'b0, "R2", DW'(rd_vld), 0);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rd_vld === 1'b0, "R11", DW'(rd_vld), 0);

    // fill addresses 0..15 with back-to-back writes
    for (int a = 0; a < 16; a++) wr1(AW'(a), 32'h1000_0000 + a * 32'h0101_0101);
    for (int a = 0; a < 16; a++) rd1(AW'(a), "R1");

    // R4: write data taken one enabled edge later; din on address edge is junk
    wr1(3, 32'h1122_3344); nop(); rd1(3, "R4");
    // R7: read in the data cycle of a pending write
    wr1(5, 32'hCAFE_0005); rd1(5, "R7");
    wr1(6, 32'h0606_0606); wr1(7, 32'h0707_0707); rd1(6, "R7"); rd1(7, "R7");
    // R5: lanes 0 and 2 enabled only
    drive(0, 1, 1, 1, 8, 4'b1010, 32'hDEAD_BEEF, 1, "R5"); rd1(8, "R5");
    drive(0, 1, 1, 1, 8, 4'b0111, 32'hAB00_0000, 1, "R5"); rd1(8, "R5");
    // R6: deselected write and read
    drive(0, 1, 1, 0, 9, 4'h0, 32'hBAD0_0009, 1, "R6"); nop(); rd1(9, "R6");
    drive(0, 1, 0, 0, 9, 4'h0, '0, 1, "R6"); nop();
    // R3: stall between write address and data; stalled inputs ignored
    wr1(10, 32'h5A5A_A5A5);
    drive(1, 1, 1, 1, 10, 4'h0, '0, 1, "R3");
    drive(1, 1, 0, 1, 11, 4'h0, '0, 1, "R3");
    nop(); rd1(10, "R3");
    // R10 and R3: output enable and hold through stalls
    rd1(11, "R10"); nop();
    drive(1, 1, 1, 1, 12, 4'h0, '0, 0, "R3");
    #6; chk(rd_vld === 1'b0 && rd_data == '0, "R10", rd_data, '0);
    drive(1, 1, 1, 1, 12, 4'h0, '0, 1, "R3");
    #6; chk(rd_vld === 1'b1 && rd_data === ref_mem[11], "R3", rd_data, ref_mem[11]);
    nop(); nop();
    // R8: linear bursts
    drive(0, 1, 1, 1, 6, 4'h0, 32'h8000_0006, 1, "R8");
    adv(1, 32'h8000_0007, "R8"); adv(1, 32'h8000_0004, "R8"); adv(1, 32'h8000_0005, "R8");
    nop();
    for (int a = 4; a < 8; a++) rd1(AW'(a), "R8");
    rd1(13, "R8"); adv(0, '0, "R8"); adv(0, '0, "R8"); adv(0, '0, "R8");
    nop(); nop();
    // R9: interleaved bursts
    ilv = 1'b1;
    drive(0, 1, 1, 1, 9, 4'h0, 32'h9000_0009, 1, "R9");
    adv(1, 32'h9000_0008, "R9"); adv(1, 32'h9000_000B, "R9"); adv(1, 32'h9000_000A, "R9");
    nop();
    for (int a = 8; a < 12; a++) rd1(AW'(a), "R9");
    rd1(2, "R9"); adv(0, '0, "R9"); adv(0, '0, "R9"); adv(0, '0, "R9");
    nop(); nop();
    // R1: random traffic, both burst orders
    for (int ph = 0; ph < 2; ph++) begin
      ilv = ph[0];
      for (int n = 0; n < 2500; n++)
        drive($urandom % 7 == 0, $urandom % 4 != 0, 1'($urandom), $urandom % 8 != 0,
              AW'($urandom % 16), 4'($urandom), DW'($urandom), $urandom % 10 != 0, "R1");
      nop(); nop(); nop();
    end
    chk(q.size() == 0, "R2", DW'(q.size()), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule